// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

The block queues the stores of one core in front of a write-back data cache. A store is taken into the queue in a single cycle and stays there until the cache accepts it. The cache is modelled as a byte array, and it takes each entry only after a fixed acceptance delay that stands in for an ownership fetch. Entries leave strictly oldest first. A full queue pushes back on the core.

Every load is compared against all pending stores. When the youngest pending store that touches the load's bytes holds all of them, the load is answered from that entry in the same cycle, even if the load begins part way into the store. When that youngest store holds only some of the load's bytes, nothing is merged. The load waits until that store has reached the cache, then reads the cache. A load that touches no pending store reads the cache at once. The core holds a load request until a response appears.

Top module: `stqf_top`

## Requirements
- R1: After reset the queue is empty, `st_ready` is 1, no response is given without `ld_valid`, and every cache byte reads 0.
- R2: A store is queued at a rising edge where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while 8 (DEPTH) stores are pending. A store offered while `st_ready` is 0 is dropped and never reaches the cache.
- R3: Entries drain oldest first. Each entry is written to the cache ACCEPT_LAT+1 cycles after it becomes the oldest (default 13), so a full queue frees its first slot 13 cycles after that entry was queued. When two stores write the same byte, the cache ends up holding the later one.
- R4: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. Data is little-endian: bits [8i+7:8i] belong to address addr+i. Load results are zero above the load size. An access never runs past the highest cache address.
- R5: A load that overlaps no pending store is answered in the cycle it is presented, with data read from the cache and `ld_resp_fwd` = 0.
- R6: When the youngest overlapping store covers every byte of the load, the load is answered in the same cycle with `ld_resp_fwd` = 1. The data is the store data shifted right by 8*(load address - store address) and cut to the load size. This holds for offset sub-reads and for single-byte accesses.
- R7: Only the youngest overlapping store decides the outcome. An older store that covers the load does not make the load forward when a younger store overlaps it only in part.
- R8: A load that is larger than the youngest overlapping store, or that reaches past either end of it, gets no response while that store is pending. Once it has drained, the load reads the cache with `ld_resp_fwd` = 0 and sees every earlier store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | 6 | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, little-endian |
| ld_valid | input | 1 | Load request, held until answered |
| ld_addr | input | 6 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_resp_valid | output | 1 | Load answered this cycle |
| ld_resp_fwd | output | 1 | Answer came from a queued store |
| ld_resp_data | output | 64 | Load data, zero above the size |

## Verification
The in-line properties check on every cycle that the fill count never exceeds the depth, and that a full queue keeps its count until a drain happens. They also check that two drains are never back to back when the delay is nonzero, that a response appears only with a request, and that a stalled load always has a pending store to wait for and never sees the queue grow on its own. Only the bench scenarios can show which entry a load forwards from, the byte alignment of offset sub-reads, the exact drain latency, that a refused store is dropped, and that the cache ends up with program-order contents. These are checked against a byte-array model that applies stores in program order.

// File: rtl/stqf_pkg.sv
`timescale 1ns/1ps
package stqf_pkg;
    localparam int ADDR_W    = 6;
    localparam int MEM_BYTES = 1 << ADDR_W;
    localparam int DATA_W    = 64;
    localparam int MAX_BYTES = DATA_W / 8;
    localparam int SZ_W      = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ADDR_W:0]   span_t;   // one extra bit so range ends never wrap
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [SZ_W-1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } size_e;

    typedef struct packed {
        addr_t addr;
        size_e size;
        data_t data;
    } store_t;

    function automatic span_t span_len(size_e s);
        return span_t'(1) << s;
    endfunction

    function automatic span_t span_end(addr_t a, size_e s);
        return {1'b0, a} + span_len(s);
    endfunction

    function automatic data_t size_mask(size_e s);
        case (s)
            SZ_B1:   return data_t'(64'h0000_0000_0000_00FF);
            SZ_B2:   return data_t'(64'h0000_0000_0000_FFFF);
            SZ_B4:   return data_t'(64'h0000_0000_FFFF_FFFF);
            default: return '1;
        endcase
    endfunction
endpackage

// File: rtl/stqf_fifo.sv
`timescale 1ns/1ps
module stqf_fifo
    import stqf_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ACCEPT_LAT = 12,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  store_t             push_entry,
    output logic               full,
    output logic [CNT_W-1:0]   count,
    output store_t [DEPTH-1:0] ordered,     // index 0 = oldest
    output logic [DEPTH-1:0]   ord_valid,
    output logic               wr_en,
    output store_t             wr_entry
);
    localparam int LAT_W = $clog2(ACCEPT_LAT + 2);

    store_t           slots [DEPTH];
    logic [IDX_W-1:0] head, tail;
    logic [LAT_W-1:0] lat_cnt;
    logic             do_push, pop;

    function automatic logic [IDX_W-1:0] nxt(logic [IDX_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign do_push  = push && !full;
    assign pop      = (count != '0) && (lat_cnt == LAT_W'(ACCEPT_LAT));
    assign wr_en    = pop;
    assign wr_entry = slots[head];

    always_ff @(posedge clk) begin
        if (do_push) slots[tail] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            tail    <= '0;
            count   <= '0;
            lat_cnt <= '0;
        end else begin
            if (do_push) tail <= nxt(tail);
            if (pop) begin
                head    <= nxt(head);
                lat_cnt <= '0;
            end else if (count != '0) begin
                lat_cnt <= lat_cnt + 1'b1;
            end
            count <= count + CNT_W'(do_push) - CNT_W'(pop);
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_view
        logic [IDX_W-1:0] slot_idx;
        assign slot_idx     = IDX_W'((int'(head) + k) % DEPTH);
        assign ordered[k]   = slots[slot_idx];
        assign ord_valid[k] = (int'(count) > k);
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    p_full_holds_r2: assert property (@(posedge clk) disable iff (rst)
        full && !pop |=> count == $past(count));

    p_drain_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        (ACCEPT_LAT > 0) && pop |=> !pop);
endmodule

// File: rtl/stqf_search.sv
`timescale 1ns/1ps
module stqf_search
    import stqf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  store_t [DEPTH-1:0] ordered,
    input  logic   [DEPTH-1:0] ord_valid,
    input  addr_t              ld_addr,
    input  size_e              ld_size,
    output logic               hit,
    output logic               contain,
    output data_t              fwd_data
);
    store_t sel;
    span_t  l_lo, l_hi, s_lo, s_hi;
    addr_t  off;

    assign l_lo = {1'b0, ld_addr};
    assign l_hi = span_end(ld_addr, ld_size);

    // Scan oldest to youngest; the last overlap seen is the youngest.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ord_valid[k] &&
                (l_lo < span_end(ordered[k].addr, ordered[k].size)) &&
                ({1'b0, ordered[k].addr} < l_hi)) begin
                hit = 1'b1;
                sel = ordered[k];
            end
        end
    end

    assign s_lo     = {1'b0, sel.addr};
    assign s_hi     = span_end(sel.addr, sel.size);
    assign contain  = hit && (l_lo >= s_lo) && (l_hi <= s_hi);
    assign off      = ld_addr - sel.addr;
    assign fwd_data = (sel.data >> {off, 3'b000}) & size_mask(ld_size);
endmodule

// File: rtl/stqf_cache.sv
`timescale 1ns/1ps
module stqf_cache
    import stqf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  store_t wr_entry,
    input  addr_t  rd_addr,
    input  size_e  rd_size,
    output data_t  rd_data
);
    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < MAX_BYTES; i++) begin
                if (span_t'(i) < span_len(wr_entry.size))
                    mem[addr_t'(wr_entry.addr + addr_t'(i))] <= wr_entry.data[8*i +: 8];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (span_t'(i) < span_len(rd_size))
                rd_data[8*i +: 8] = mem[addr_t'(rd_addr + addr_t'(i))];
        end
    end
endmodule

// File: rtl/stqf_top.sv
`timescale 1ns/1ps
module stqf_top
    import stqf_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ACCEPT_LAT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    output logic              ld_resp_valid,
    output logic              ld_resp_fwd,
    output logic [DATA_W-1:0] ld_resp_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    store_t             push_entry, wr_entry;
    store_t [DEPTH-1:0] ordered;
    logic   [DEPTH-1:0] ord_valid;
    logic   [CNT_W-1:0] count;
    logic               full, wr_en, hit, contain, push;
    data_t              fwd_data, cache_data;

    assign push_entry = '{addr: st_addr, size: size_e'(st_size), data: st_data};
    assign st_ready   = !full;
    assign push       = st_valid;

    stqf_fifo #(.DEPTH(DEPTH), .ACCEPT_LAT(ACCEPT_LAT)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_entry(push_entry),
        .full(full), .count(count), .ordered(ordered), .ord_valid(ord_valid),
        .wr_en(wr_en), .wr_entry(wr_entry)
    );

    stqf_search #(.DEPTH(DEPTH)) u_search (
        .ordered(ordered), .ord_valid(ord_valid),
        .ld_addr(ld_addr), .ld_size(size_e'(ld_size)),
        .hit(hit), .contain(contain), .fwd_data(fwd_data)
    );

    stqf_cache u_cache (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_entry(wr_entry),
        .rd_addr(ld_addr), .rd_size(size_e'(ld_size)), .rd_data(cache_data)
    );

    assign ld_resp_valid = ld_valid && (!hit || contain);
    assign ld_resp_fwd   = ld_valid && contain;
    assign ld_resp_data  = !ld_resp_valid ? '0 : (contain ? fwd_data : cache_data);

    p_resp_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        ld_resp_valid |-> ld_valid);

    p_stall_has_entry_r8: assert property (@(posedge clk) disable iff (rst)
        ld_valid && !ld_resp_valid |-> count != '0);

    p_stall_drains_r8: assert property (@(posedge clk) disable iff (rst)
        ld_valid && !ld_resp_valid && !(st_valid && st_ready) |=> count <= $past(count));
endmodule

// File: tb/stqf_top_tb.sv
`timescale 1ns/1ps
module stqf_top_tb;
    localparam int DEPTH = 8;
    localparam int LAT   = 12;
    localparam int NROW  = 7;

    // Stimulus table: store, then an overlapping (or not) load.
    localparam logic [5:0]  V_SA [NROW] = '{6'd10, 6'd20, 6'd24, 6'd32, 6'd40, 6'd48, 6'd56};
    localparam logic [1:0]  V_SS [NROW] = '{2'd2, 2'd0, 2'd3, 2'd1, 2'd2, 2'd3, 2'd0};
    localparam logic [63:0] V_SD [NROW] = '{64'hA1B2C3D4, 64'h5A, 64'h1122334455667788,
                                           64'hBEEF, 64'hCAFEF00D, 64'h0102030405060708, 64'h77};
    localparam logic [5:0]  V_LA [NROW] = '{6'd12, 6'd20, 6'd27, 6'd32, 6'd38, 6'd48, 6'd57};
    localparam logic [1:0]  V_LS [NROW] = '{2'd1, 2'd0, 2'd2, 2'd2, 2'd2, 2'd3, 2'd0};
    localparam logic        V_FW [NROW] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic        V_ST [NROW] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid, st_ready, ld_valid, ld_resp_valid, ld_resp_fwd;
    logic [5:0]  st_addr, ld_addr;
    logic [1:0]  st_size, ld_size;
    logic [63:0] st_data, ld_resp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [64];

    always #5 clk = ~clk;

    stqf_top #(.DEPTH(DEPTH), .ACCEPT_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_resp_valid(ld_resp_valid), .ld_resp_fwd(ld_resp_fwd),
        .ld_resp_data(ld_resp_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_read(input logic [5:0] a, input logic [1:0] sz);
        logic [63:0] r = '0;
        for (int i = 0; i < (1 << sz); i++) r[8*i +: 8] = ref_mem[a + i];
        return r;
    endfunction

    // Called at a negedge; returns at the negedge after the store was taken.
    task automatic put_store(input logic [5:0] a, input logic [1:0] sz, input logic [63:0] d);
        st_valid = 1'b1; st_addr = a; st_size = sz; st_data = d;
        #1;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
        for (int i = 0; i < (1 << sz); i++) ref_mem[a + i] = d[8*i +: 8];
    endtask

    task automatic do_load(input logic [5:0] a, input logic [1:0] sz,
                           output logic [63:0] d, output logic f, output int stalls);
        ld_valid = 1'b1; ld_addr = a; ld_size = sz; stalls = 0;
        #1;
        while (!ld_resp_valid) begin
            @(negedge clk); #1;
            stalls++;
        end
        d = ld_resp_data; f = ld_resp_fwd;
        ld_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_drain();
        repeat (DEPTH * (LAT + 1) + 4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] d;
        logic        f;
        int          st, k;
        for (int i = 0; i < 64; i++) ref_mem[i] = 8'h00;
        rst = 1'b1; st_valid = 1'b0; ld_valid = 1'b0;
        st_addr = '0; st_size = '0; st_data = '0; ld_addr = '0; ld_size = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 st_ready", 64'(st_ready), 64'd1);
        check("R1 no resp", 64'(ld_resp_valid), 64'd0);
        do_load(6'd0, 2'd3, d, f, st);
        check("R1 cache zero", d, 64'd0);
        check("R5 no fwd on empty", 64'(f), 64'd0);

        // Table walk: R4 R5 R6 R8
        for (int r = 0; r < NROW; r++) begin
            put_store(V_SA[r], V_SS[r], V_SD[r]);
            do_load(V_LA[r], V_LS[r], d, f, st);
            check($sformatf("R6 row%0d fwd", r), 64'(f), 64'(V_FW[r]));
            check($sformatf("R4 row%0d data", r), d, ref_read(V_LA[r], V_LS[r]));
            check($sformatf("R8 row%0d stalled", r), 64'(st > 0), 64'(V_ST[r]));
        end
        wait_drain();
        do_load(6'd10, 2'd2, d, f, st);
        check("R5 cache read data", d, 64'hA1B2C3D4);
        check("R5 cache read fwd", 64'(f), 64'd0);

        // R7: youngest partial store blocks an older covering one
        put_store(6'd0, 2'd2, 64'h11111111);
        put_store(6'd1, 2'd0, 64'h22);
        do_load(6'd0, 2'd2, d, f, st);
        check("R7 stalled", 64'(st > 0), 64'd1);
        check("R7 fwd", 64'(f), 64'd0);
        check("R8 merged data", d, 64'h11112211);
        put_store(6'd4, 2'd2, 64'hAAAAAAAA);
        put_store(6'd4, 2'd2, 64'hBBBBBBBB);
        do_load(6'd6, 2'd1, d, f, st);
        check("R7 youngest data", d, 64'hBBBB);
        check("R7 youngest fwd", 64'(f), 64'd1);
        wait_drain();

        // R3: same-byte order
        put_store(6'd50, 2'd0, 64'h01);
        put_store(6'd50, 2'd0, 64'h02);
        do_load(6'd50, 2'd0, d, f, st);
        check("R6 single byte fwd", 64'(f), 64'd1);
        check("R3 pending youngest", d, 64'h02);
        wait_drain();
        do_load(6'd50, 2'd0, d, f, st);
        check("R3 final byte", d, 64'h02);

        // R2/R3: fill, backpressure, dropped store, drain latency
        for (int i = 0; i < DEPTH; i++) put_store(6'(i), 2'd0, 64'(8'h30 + i));
        #1;
        check("R2 full not ready", 64'(st_ready), 64'd0);
        st_valid = 1'b1; st_addr = 6'd62; st_size = 2'd0; st_data = 64'hEE;
        @(negedge clk);
        st_valid = 1'b0;
        k = 1;
        while (!st_ready) begin @(negedge clk); k++; end
        check("R3 first slot free", 64'(k), 64'(LAT + 1 - (DEPTH - 1)));
        wait_drain();
        do_load(6'd62, 2'd0, d, f, st);
        check("R2 dropped store", d, 64'd0);
        do_load(6'd0, 2'd3, d, f, st);
        check("R3 drained bytes", d, ref_read(6'd0, 2'd3));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule